// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer Group

This block holds a set of independent 64-bit timers, two by default, behind a simple single-cycle register bus. Each timer counts up or down once per prescaled tick. The prescaler divides the clock by a 16-bit code, where code 0 selects the longest period of 65536 cycles. Software sets the counter by staging a 64-bit value in two 32-bit load registers and then writing a trigger register. It reads the counter coherently by writing a snapshot register, which freezes both 32-bit halves from the same clock cycle.

Each timer has a one-shot alarm comparator. When the alarm is armed and the counter equals the alarm value, the timer sets its raw interrupt bit and disarms itself. If auto-reload is set, the counter takes the load value on the next tick instead of stepping. A group-level enable mask gates the raw bits. Each timer then drives a level interrupt, an edge pulse, or both. Pending bits are cleared by writing ones to a clear register.

Register map, word addresses: timer t occupies addresses 16*t + offset. Offset 0 is control. Offset 1 is the snapshot trigger (write). Offsets 2 and 3 are the snapshot low and high words (read). Offsets 4 and 5 are the load low and high words. Offset 6 is the load trigger (write). Offsets 7 and 8 are the alarm low and high words. The group block sits at 16*NUM_TIMERS: +0 is the enable mask, +1 is raw status (read), +2 is masked status (read) and +3 is the clear register (write). Control bits: 0 run, 1 count up, 2 auto-reload, 3 alarm armed, 4 level interrupt enable, 5 edge interrupt enable, 31:16 divider code. Bit N of every group register belongs to timer N.

Top module: `tg_timer_group`

## Requirements
- R1: After reset, every readable register reads 0 and both interrupt outputs are 0.
- R2: While run (control bit 0) is 1, the counter steps once every P cycles, where P is the divider code (control bits 31:16). While run is 0, the counter holds.
- R3: A divider code of 0 gives P = 65536. A code of 65535 gives P = 65535.
- R4: With control bit 1 set to 1 the counter increments; with it at 0 the counter decrements. Both wrap modulo 2^64, and carries cross the 32-bit halves.
- R5: A write to offset 1 copies the live 64-bit counter into the snapshot words at offsets 2 (low) and 3 (high). These words stay unchanged until the next snapshot write.
- R6: A write to offset 6 copies {load high, load low} into the counter. The load words read back as written.
- R7: When alarm armed (control bit 3) is 1 and the counter equals {alarm high, alarm low}, the timer's raw status bit is set and control bit 3 reads 0 afterwards.
- R8: After an alarm with auto-reload (control bit 2) set, the next tick loads the load value into the counter instead of stepping.
- R9: Masked status is raw AND enable mask. irq_level[N] is high while masked bit N and control bit 4 of timer N are both 1.
- R10: irq_edge[N] is a single-cycle pulse, one cycle after the alarm matches, when control bit 5 and enable mask bit N are 1.
- R11: Writing 1 to bit N of the clear register clears raw bit N. If an alarm match occurs in the same cycle, the bit stays set.
- R12: A write to the control register restarts the prescaler, so the next tick comes a full period P after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_level | output | NUM_TIMERS | Level interrupt per timer |
| irq_edge | output | NUM_TIMERS | Edge interrupt pulse per timer |

## Verification
The bench builds the block with its default parameters: two timers, a 32-bit bus and a 16-bit divider, which gives a 64-bit counter. Staged loads near the limits bring the carry from the low word into the high word, and the wrap below zero when counting down, within a few cycles. A 16-bit divider keeps the longest period of 65536 cycles, and the code next to it, short enough to run in full. With two timers, the group masks and the clear-versus-alarm collision can be exercised on one timer while the other holds its state.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int OFS_W = 4;

    // per-timer word offsets
    localparam logic [OFS_W-1:0] T_CTRL     = 4'd0;
    localparam logic [OFS_W-1:0] T_SNAP     = 4'd1;
    localparam logic [OFS_W-1:0] T_VIEW_LO  = 4'd2;
    localparam logic [OFS_W-1:0] T_VIEW_HI  = 4'd3;
    localparam logic [OFS_W-1:0] T_LOAD_LO  = 4'd4;
    localparam logic [OFS_W-1:0] T_LOAD_HI  = 4'd5;
    localparam logic [OFS_W-1:0] T_RELOAD   = 4'd6;
    localparam logic [OFS_W-1:0] T_ALARM_LO = 4'd7;
    localparam logic [OFS_W-1:0] T_ALARM_HI = 4'd8;

    // group word offsets
    localparam logic [OFS_W-1:0] G_IE     = 4'd0;
    localparam logic [OFS_W-1:0] G_RAW    = 4'd1;
    localparam logic [OFS_W-1:0] G_MASKED = 4'd2;
    localparam logic [OFS_W-1:0] G_CLEAR  = 4'd3;

    // control bit positions
    localparam int B_RUN   = 0;
    localparam int B_UP    = 1;
    localparam int B_AUTO  = 2;
    localparam int B_ALARM = 3;
    localparam int B_LVL   = 4;
    localparam int B_EDGE  = 5;
    localparam int B_DIV   = 16;

    typedef struct packed {
        logic run;
        logic up;
        logic auto_rl;
        logic alarm_en;
        logic lvl_ie;
        logic edge_ie;
    } ctrl_t;
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    localparam int PC_W = DIV_W + 1;

    logic [DIV_W-1:0] pc_d, pc_q;
    logic [PC_W-1:0]  period;
    logic             at_end;

    always_comb begin
        period = (div_code == '0) ? (PC_W'(1) << DIV_W) : {1'b0, div_code};
        at_end = ({1'b0, pc_q} == (period - PC_W'(1)));
        pc_d   = pc_q;
        tick   = 1'b0;
        if (restart) begin
            pc_d = '0;
        end else if (run) begin
            if (at_end) begin
                tick = 1'b1;
                pc_d = '0;
            end else begin
                pc_d = pc_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/tg_channel.sv
module tg_channel #(
    parameter int CNT_W = 64,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             up,
    input  logic             auto_rl,
    input  logic             alarm_en,
    input  logic [DIV_W-1:0] div_code,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             snap_we,
    input  logic             reload_we,
    input  logic             div_we,
    output logic             fire,
    output logic [CNT_W-1:0] view,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] view;
        logic             pend;
    } chan_t;

    chan_t d, q;
    logic  tick;

    tg_prescaler #(.DIV_W(DIV_W)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (div_we | reload_we),
        .div_code (div_code),
        .tick     (tick)
    );

    always_comb begin
        d    = q;
        fire = alarm_en && (q.cnt == alarm_val);
        if (snap_we) d.view = q.cnt;
        if (reload_we) begin
            d.cnt  = load_val;
            d.pend = 1'b0;
        end else if (tick) begin
            if (q.pend) begin
                d.cnt  = load_val;
                d.pend = 1'b0;
            end else if (up) begin
                d.cnt = q.cnt + CNT_W'(1);
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
        if (fire && auto_rl) d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign view = q.view;
    assign cnt  = q.cnt;
endmodule

// File: rtl/tg_timer_group.sv
module tg_timer_group
    import tg_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int BUS_W      = 32,
    parameter int DIV_W      = 16,
    localparam int CNT_W     = 2 * BUS_W,
    localparam int ADDR_W    = $clog2((NUM_TIMERS + 1) * (1 << OFS_W))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic [NUM_TIMERS-1:0] irq_level,
    output logic [NUM_TIMERS-1:0] irq_edge
);
    localparam int TSEL_W = ADDR_W - OFS_W;

    typedef struct packed {
        ctrl_t [NUM_TIMERS-1:0]                 flags;
        logic  [NUM_TIMERS-1:0][DIV_W-1:0]      div;
        logic  [NUM_TIMERS-1:0][CNT_W-1:0]      load;
        logic  [NUM_TIMERS-1:0][CNT_W-1:0]      alarm;
        logic  [NUM_TIMERS-1:0]                 ie;
        logic  [NUM_TIMERS-1:0]                 raw;
        logic  [NUM_TIMERS-1:0]                 edge_p;
    } regs_t;

    regs_t d, q;

    logic [TSEL_W-1:0] tsel;
    logic [OFS_W-1:0]  ofs;
    logic              grp_hit;
    logic [NUM_TIMERS-1:0] ctrl_we, snap_we, reload_we_v;
    logic [NUM_TIMERS-1:0] fire_v, alarm_en_v, run_v, lvl_v, edg_v;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] view_v, cnt_v;
    logic [NUM_TIMERS-1:0] clr_mask;

    assign tsel    = bus_addr[ADDR_W-1:OFS_W];
    assign ofs     = bus_addr[OFS_W-1:0];
    assign grp_hit = (tsel == TSEL_W'(NUM_TIMERS));

    always_comb begin
        for (int t = 0; t < NUM_TIMERS; t++) begin
            ctrl_we[t]     = bus_we && (tsel == TSEL_W'(t)) && (ofs == T_CTRL);
            snap_we[t]     = bus_we && (tsel == TSEL_W'(t)) && (ofs == T_SNAP);
            reload_we_v[t] = bus_we && (tsel == TSEL_W'(t)) && (ofs == T_RELOAD);
            alarm_en_v[t]  = q.flags[t].alarm_en;
            run_v[t]       = q.flags[t].run;
            lvl_v[t]       = q.flags[t].lvl_ie;
            edg_v[t]       = q.flags[t].edge_ie;
        end
        clr_mask = (bus_we && grp_hit && ofs == G_CLEAR) ? bus_wdata[NUM_TIMERS-1:0] : '0;
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_ch
        tg_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (q.flags[t].run),
            .up        (q.flags[t].up),
            .auto_rl   (q.flags[t].auto_rl),
            .alarm_en  (q.flags[t].alarm_en),
            .div_code  (q.div[t]),
            .load_val  (q.load[t]),
            .alarm_val (q.alarm[t]),
            .snap_we   (snap_we[t]),
            .reload_we (reload_we_v[t]),
            .div_we    (ctrl_we[t]),
            .fire      (fire_v[t]),
            .view      (view_v[t]),
            .cnt       (cnt_v[t])
        );
    end

    always_comb begin
        d = q;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (bus_we && tsel == TSEL_W'(t)) begin
                case (ofs)
                    T_CTRL: begin
                        d.flags[t].run      = bus_wdata[B_RUN];
                        d.flags[t].up       = bus_wdata[B_UP];
                        d.flags[t].auto_rl  = bus_wdata[B_AUTO];
                        d.flags[t].alarm_en = bus_wdata[B_ALARM];
                        d.flags[t].lvl_ie   = bus_wdata[B_LVL];
                        d.flags[t].edge_ie  = bus_wdata[B_EDGE];
                        d.div[t]            = bus_wdata[B_DIV +: DIV_W];
                    end
                    T_LOAD_LO:  d.load[t][BUS_W-1:0]      = bus_wdata;
                    T_LOAD_HI:  d.load[t][CNT_W-1:BUS_W]  = bus_wdata;
                    T_ALARM_LO: d.alarm[t][BUS_W-1:0]     = bus_wdata;
                    T_ALARM_HI: d.alarm[t][CNT_W-1:BUS_W] = bus_wdata;
                    default: ;
                endcase
            end
            // a match disarms the alarm even against a same-cycle write
            if (fire_v[t]) d.flags[t].alarm_en = 1'b0;
        end
        if (bus_we && grp_hit && ofs == G_IE) d.ie = bus_wdata[NUM_TIMERS-1:0];
        d.raw    = (q.raw & ~clr_mask) | fire_v;
        d.edge_p = fire_v & q.ie & edg_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_level = q.raw & q.ie & lvl_v;
    assign irq_edge  = q.edge_p;

    always_comb begin
        bus_rdata = '0;
        if (grp_hit) begin
            case (ofs)
                G_IE:     bus_rdata[NUM_TIMERS-1:0] = q.ie;
                G_RAW:    bus_rdata[NUM_TIMERS-1:0] = q.raw;
                G_MASKED: bus_rdata[NUM_TIMERS-1:0] = q.raw & q.ie;
                default: ;
            endcase
        end else begin
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (tsel == TSEL_W'(t)) begin
                    case (ofs)
                        T_CTRL: begin
                            bus_rdata[B_RUN]          = q.flags[t].run;
                            bus_rdata[B_UP]           = q.flags[t].up;
                            bus_rdata[B_AUTO]         = q.flags[t].auto_rl;
                            bus_rdata[B_ALARM]        = q.flags[t].alarm_en;
                            bus_rdata[B_LVL]          = q.flags[t].lvl_ie;
                            bus_rdata[B_EDGE]         = q.flags[t].edge_ie;
                            bus_rdata[B_DIV +: DIV_W] = q.div[t];
                        end
                        T_VIEW_LO:  bus_rdata = view_v[t][BUS_W-1:0];
                        T_VIEW_HI:  bus_rdata = view_v[t][CNT_W-1:BUS_W];
                        T_LOAD_LO:  bus_rdata = q.load[t][BUS_W-1:0];
                        T_LOAD_HI:  bus_rdata = q.load[t][CNT_W-1:BUS_W];
                        T_ALARM_LO: bus_rdata = q.alarm[t][BUS_W-1:0];
                        T_ALARM_HI: bus_rdata = q.alarm[t][CNT_W-1:BUS_W];
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tg_timer_group_chk.sv
module tg_timer_group_chk #(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 64
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_TIMERS-1:0]            irq_edge,
    input logic [NUM_TIMERS-1:0]            fire,
    input logic [NUM_TIMERS-1:0]            alarm_en,
    input logic [NUM_TIMERS-1:0]            raw,
    input logic [NUM_TIMERS-1:0]            run,
    input logic [NUM_TIMERS-1:0]            reload_we,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt
);
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_a
        a_r7_alarm_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> !alarm_en[i]);
        a_r7_raw_sets: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> raw[i]);
        a_r10_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
            irq_edge[i] |=> !irq_edge[i]);
        a_r10_edge_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_edge[i]) |-> $past(fire[i]));
        a_r2_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !reload_we[i]) |=> $stable(cnt[i]));
    end
endmodule

bind tg_timer_group tg_timer_group_chk #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_edge  (irq_edge),
    .fire      (fire_v),
    .alarm_en  (alarm_en_v),
    .raw       (q.raw),
    .run       (run_v),
    .reload_we (reload_we_v),
    .cnt       (cnt_v)
);

// File: tb/tg_timer_group_tb.sv
module tg_timer_group_tb_top;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_level, irq_edge;

    int checks = 0;
    int errors = 0;
    int edge0_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tg_timer_group dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_edge(irq_edge)
    );

    always @(negedge clk) if (rst_n && irq_edge[0]) edge0_cnt++;

    typedef struct packed {
        logic [15:0] div;
        logic        up;
        logic [63:0] load;
        logic [31:0] wait_n;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd2,     1'b1, 64'd0,          32'd10},
        '{16'd3,     1'b1, 64'd100,        32'd10},
        '{16'd5,     1'b0, 64'd50,         32'd23},
        '{16'd2,     1'b0, 64'd0,          32'd5},
        '{16'd7,     1'b1, 64'hFFFF_FFFF,  32'd14},
        '{16'd0,     1'b1, 64'd0,          32'd65540},
        '{16'hFFFF,  1'b1, 64'd0,          32'd65535}
    };

    function automatic logic [AW-1:0] ta(int t, int o);
        return AW'(t * 16 + o);
    endfunction

    function automatic logic [31:0] mk(bit run, bit up, bit au, bit al, bit lv, bit ed, logic [15:0] dv);
        return {dv, 10'd0, ed, lv, al, au, up, run};
    endfunction

    // called at a falling edge; the write takes effect at the next rising edge
    task automatic wr(logic [AW-1:0] a, logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd64(int t, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(ta(t, 2), lo);
        rd(ta(t, 3), hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [63:0] v, v2, exp;
        int unsigned eff;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(ta(0, 0), r);  chk("R1 ctrl0", r, 0);
        rd(ta(1, 2), r);  chk("R1 view1", r, 0);
        rd(ta(1, 7), r);  chk("R1 alarm1", r, 0);
        rd(ta(2, 0), r);  chk("R1 ie", r, 0);
        rd(ta(2, 1), r);  chk("R1 raw", r, 0);
        chk("R1 irq", {irq_level, irq_edge}, 0);

        // vector walk: R2 R3 R4 R5
        foreach (VECS[i]) begin
            wr(ta(0, 0), 0);
            wr(ta(0, 4), VECS[i].load[31:0]);
            wr(ta(0, 5), VECS[i].load[63:32]);
            wr(ta(0, 6), 0);
            wr(ta(0, 0), mk(1, VECS[i].up, 0, 0, 0, 0, VECS[i].div));
            repeat (VECS[i].wait_n) @(negedge clk);
            wr(ta(0, 1), 0);
            eff = (VECS[i].div == 0) ? 65536 : VECS[i].div;
            exp = VECS[i].up ? VECS[i].load + 64'(VECS[i].wait_n / eff)
                             : VECS[i].load - 64'(VECS[i].wait_n / eff);
            rd64(0, v);
            chk($sformatf("R2 R3 R4 vector %0d", i), v, exp);
            repeat (9) @(negedge clk);
            rd64(0, v2);
            chk($sformatf("R5 snapshot stable %0d", i), v2, exp);
        end

        // R2 pause holds
        wr(ta(0, 0), mk(0, 1, 0, 0, 0, 0, 16'd2));
        wr(ta(0, 1), 0);
        rd64(0, v);
        repeat (10) @(negedge clk);
        wr(ta(0, 1), 0);
        rd64(0, v2);
        chk("R2 paused holds", v2, v);

        // alarm with auto-reload on timer 0: R6 R7 R8 R9 R10
        wr(ta(0, 4), 0);
        wr(ta(0, 5), 0);
        wr(ta(0, 6), 0);
        wr(ta(0, 4), 100);
        rd(ta(0, 4), r); chk("R6 load readback", r, 100);
        wr(ta(0, 7), 5);
        wr(ta(0, 8), 0);
        wr(ta(2, 0), 1);
        edge0_cnt = 0;
        wr(ta(0, 0), mk(1, 1, 1, 1, 1, 1, 16'd2));
        repeat (13) @(negedge clk);
        wr(ta(0, 1), 0);
        rd64(0, v); chk("R8 reload after alarm", v, 100);
        rd(ta(2, 1), r); chk("R7 raw set", r, 1);
        rd(ta(0, 0), r); chk("R7 alarm disarmed", r[3], 0);
        chk("R9 level high", irq_level[0], 1);
        repeat (20) @(negedge clk);
        chk("R10 single edge pulse", edge0_cnt, 1);
        rd(ta(2, 2), r); chk("R9 masked on", r, 1);
        wr(ta(2, 0), 0);
        rd(ta(2, 2), r); chk("R9 masked off", r, 0);
        chk("R9 level off", irq_level[0], 0);
        rd(ta(2, 1), r); chk("R9 raw kept", r, 1);
        wr(ta(2, 0), 1);
        chk("R9 level back", irq_level[0], 1);
        wr(ta(2, 3), 1);
        rd(ta(2, 1), r); chk("R11 clear", r, 0);
        chk("R11 level cleared", irq_level[0], 0);

        // R6 load into counter on timer 1, R11 alarm wins over clear
        wr(ta(1, 0), 0);
        wr(ta(1, 4), 7);
        wr(ta(1, 6), 0);
        wr(ta(1, 1), 0);
        rd64(1, v); chk("R6 load copied", v, 7);
        wr(ta(1, 7), 7);
        wr(ta(2, 0), 3);
        wr(ta(1, 0), mk(0, 1, 0, 1, 1, 0, 16'd2));
        wr(ta(2, 3), 2);
        rd(ta(2, 1), r); chk("R11 alarm wins", r, 2);
        chk("R11 level1", irq_level[1], 1);
        wr(ta(2, 3), 2);
        rd(ta(2, 1), r); chk("R11 clear after", r, 0);

        // R12 control write restarts prescaler
        wr(ta(0, 0), 0);
        wr(ta(0, 4), 0);
        wr(ta(0, 6), 0);
        wr(ta(0, 0), mk(1, 1, 0, 0, 0, 0, 16'd4));
        repeat (2) @(negedge clk);
        wr(ta(0, 0), mk(1, 1, 0, 0, 0, 0, 16'd4));
        @(negedge clk);
        wr(ta(0, 1), 0);
        rd64(0, v); chk("R12 restart delays tick", v, 0);
        repeat (2) @(negedge clk);
        wr(ta(0, 1), 0);
        rd64(0, v); chk("R12 tick after full period", v, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule